// File: doc/BRIEF.md
# Chained Descriptor Frame Fetcher

This block fills a display's pixel FIFO by following a linked list of descriptors held in memory. Software writes the address of the first descriptor and sets a start bit. The engine then reads each descriptor (four words), streams the data region it names into the FIFO one word at a time, and moves on to the descriptor that the current one points to. Because every descriptor has its own source address, one frame can be split between memories of different speed. A chain whose last descriptor points back at the first repeats the frame forever with no further software work.

Each descriptor can ask for an interrupt when its own data has been sent. This lets software learn, part way through a frame, that the engine has left one memory region for another. A separate sticky flag records any cycle in which the display asked for a pixel while the FIFO was empty. Memory reads use a plain request/accept/response port with one read in flight at a time.

Top module: `desc_frame_fetch`

## Requirements
- R1: While reset is held, and after it, the block is idle: no memory request, no FIFO write, and the interrupt and underrun outputs are low.
- R2: Writing register 1 with bit 0 set while idle makes the engine request, from the cycle after the write, the four descriptor words at the address held in register 0, at offsets +0, +4, +8, +12 in that order.
- R3: Descriptor word 0 is the next-descriptor address, word 1 the source address, word 2 the byte length (its two low bits are ignored), and word 3 the control word. The engine reads length/4 data words from the source address upward in steps of 4, and writes each returned data word to the FIFO in the same cycle as its response.
- R4: After the last data word of a descriptor, the next request, issued in the cycle after that response, is word 0 of the descriptor named by word 0. A chain that points back to its head repeats with no limit.
- R5: A descriptor whose length is zero produces no data reads, and the request for the next descriptor follows the control-word response at once.
- R6: No data read is requested in a cycle where the FIFO-full input is high. Descriptor reads are not held back by it.
- R7: When bit 0 of a descriptor's control word is set, the interrupt output goes high in the cycle after that descriptor's final data response, or after its control-word response if its length is zero. It then stays high.
- R8: Writing register 2 clears the interrupt for data bit 0 set and the underrun flag for bit 1 set. A set event in the same cycle takes priority over the clear.
- R9: A cycle where the display requests data while the FIFO-empty input is high sets the underrun output from the next cycle on.
- R10: A start write while the engine is already running has no effect on the sequence of requests.
- R11: Only one read is outstanding at a time. The request drops in the cycle after it is accepted and returns in the cycle after the response, unless R6 holds it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | CFG_AW | Register select: 0 head address, 1 control, 2 status clear |
| cfgWrData | input | DATA_W | Register write data |
| memReq | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Byte address of the read |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRspValid | input | 1 | Read data returned this cycle |
| memRspData | input | DATA_W | Read data |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | DATA_W | Pixel word written to the FIFO |
| fifoFull | input | 1 | FIFO has no room |
| fifoEmpty | input | 1 | FIFO holds no data |
| dispReq | input | 1 | Display pulls a pixel word this cycle |
| irq | output | 1 | Level interrupt, per-descriptor completion |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Each result has a fixed latency. A request appears one cycle after the start write or after the response that ends the previous read. A FIFO write appears in the same cycle as its data response. The interrupt and underrun flags change one cycle after the event that sets or clears them. The bench drives its inputs at the falling edge and samples a moment later, so each cycle's comparison sees the state left by the last rising edge and the combinational response to the inputs just driven. Its reference model advances its queues and flags only after that comparison, so an expected value always lines up with the edge that produces it.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int DESC_WORDS = 4;
  localparam int REG_HEAD = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_STAT = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_PREQ, ST_PWAIT
  } fetchState_t;

  typedef struct packed {
    logic loadHead;   // descriptor pointer <= head register
    logic capWord;    // capture returned descriptor word
    logic nextWord;   // advance descriptor word index
    logic beat;       // data word returned: step address, count down
    logic chain;      // descriptor pointer <= next pointer
    logic descDone;   // descriptor finished (interrupt point)
    logic dataPhase;  // address mux selects the data address
  } fetchCtl_t;
endpackage

// File: rtl/fetch_dpath.sv
module fetch_dpath import fetch_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchCtl_t         ctl,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              dispReq,
  input  logic              fifoEmpty,
  output logic              startReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lastWord,
  output logic              lenZero,
  output logic              lastBeat,
  output logic              irq,
  output logic              underrun
);
  localparam int STEP  = DATA_W / 8;
  localparam int OFS   = $clog2(STEP);
  localparam int IDX_W = $clog2(DESC_WORDS);

  logic [ADDR_W-1:0] headReg, descPtr, nextPtr, curAddr;
  logic [LEN_W-1:0]  remBytes;
  logic [IDX_W-1:0]  wordIdx;
  logic              irqEnReg, irqEnEff, irqSet, irqClr, undSet, undClr, statWr;

  assign statWr   = cfgWrEn && (cfgAddr == CFG_AW'(REG_STAT));
  assign startReq = cfgWrEn && (cfgAddr == CFG_AW'(REG_CTRL)) && cfgWrData[0];
  assign lastWord = (wordIdx == IDX_W'(DESC_WORDS - 1));
  assign lenZero  = (remBytes == '0);
  assign lastBeat = (remBytes == LEN_W'(STEP));
  assign memAddr  = ctl.dataPhase ? curAddr
                                  : descPtr + ADDR_W'({wordIdx, {OFS{1'b0}}});

  // zero-length descriptors report using the control word just returned
  assign irqEnEff = (ctl.capWord && lastWord) ? memRspData[0] : irqEnReg;
  assign irqSet   = ctl.descDone && irqEnEff;
  assign irqClr   = statWr && cfgWrData[0];
  assign undSet   = dispReq && fifoEmpty;
  assign undClr   = statWr && cfgWrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headReg  <= '0;
      descPtr  <= '0;
      nextPtr  <= '0;
      curAddr  <= '0;
      remBytes <= '0;
      wordIdx  <= '0;
      irqEnReg <= 1'b0;
      irq      <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (cfgWrEn && (cfgAddr == CFG_AW'(REG_HEAD)))
        headReg <= cfgWrData[ADDR_W-1:0];
      if (ctl.capWord) begin
        case (wordIdx)
          IDX_W'(0): nextPtr  <= memRspData[ADDR_W-1:0];
          IDX_W'(1): curAddr  <= memRspData[ADDR_W-1:0];
          IDX_W'(2): remBytes <= {memRspData[LEN_W-1:OFS], {OFS{1'b0}}};
          default:   irqEnReg <= memRspData[0];
        endcase
      end
      if (ctl.nextWord) wordIdx <= wordIdx + 1'b1;
      if (ctl.beat) begin
        curAddr  <= curAddr + ADDR_W'(STEP);
        remBytes <= remBytes - LEN_W'(STEP);
      end
      if (ctl.loadHead) begin
        descPtr <= headReg;
        wordIdx <= '0;
      end
      if (ctl.chain) begin
        descPtr <= nextPtr;
        wordIdx <= '0;
      end
      irq      <= irqSet | (irq & ~irqClr);
      underrun <= undSet | (underrun & ~undClr);
    end
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl import fetch_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      memReady,
  input  logic      memRspValid,
  input  logic      fifoFull,
  input  logic      lastWord,
  input  logic      lenZero,
  input  logic      lastBeat,
  output logic      memReq,
  output fetchCtl_t ctl
);
  fetchState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    memReq   = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        ctl.loadHead = 1'b1;
        stateNxt     = ST_DREQ;
      end
      ST_DREQ: begin
        memReq = 1'b1;
        if (memReady) stateNxt = ST_DWAIT;
      end
      ST_DWAIT: if (memRspValid) begin
        ctl.capWord = 1'b1;
        if (!lastWord) begin
          ctl.nextWord = 1'b1;
          stateNxt     = ST_DREQ;
        end else if (lenZero) begin
          ctl.descDone = 1'b1;
          ctl.chain    = 1'b1;
          stateNxt     = ST_DREQ;
        end else begin
          stateNxt = ST_PREQ;
        end
      end
      ST_PREQ: begin
        ctl.dataPhase = 1'b1;
        memReq        = !fifoFull;
        if (!fifoFull && memReady) stateNxt = ST_PWAIT;
      end
      ST_PWAIT: begin
        ctl.dataPhase = 1'b1;
        if (memRspValid) begin
          ctl.beat = 1'b1;
          if (lastBeat) begin
            ctl.descDone = 1'b1;
            ctl.chain    = 1'b1;
            stateNxt     = ST_DREQ;
          end else begin
            stateNxt = ST_PREQ;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/desc_frame_fetch.sv
module desc_frame_fetch import fetch_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              dispReq,
  output logic              irq,
  output logic              underrun
);
  fetchCtl_t ctl;
  logic startReq, lastWord, lenZero, lastBeat, dataPhase;

  assign dataPhase  = ctl.dataPhase;
  assign fifoWrEn   = ctl.beat;
  assign fifoWrData = memRspData;

  fetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memReady(memReady),
    .memRspValid(memRspValid), .fifoFull(fifoFull), .lastWord(lastWord),
    .lenZero(lenZero), .lastBeat(lastBeat), .memReq(memReq), .ctl(ctl)
  );

  fetch_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CFG_AW(CFG_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .memRspData(memRspData), .dispReq(dispReq),
    .fifoEmpty(fifoEmpty), .startReq(startReq), .memAddr(memAddr),
    .lastWord(lastWord), .lenZero(lenZero), .lastBeat(lastBeat),
    .irq(irq), .underrun(underrun)
  );
endmodule

// File: rtl/fetch_chk.sv
module fetch_chk #(
  parameter int DATA_W = 32,
  parameter int CFG_AW = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memReady,
  input logic              memRspValid,
  input logic              fifoWrEn,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic              dispReq,
  input logic              irq,
  input logic              underrun,
  input logic              dataPhase,
  input logic              cfgWrEn,
  input logic [CFG_AW-1:0] cfgAddr,
  input logic [DATA_W-1:0] cfgWrData
);
  // R6
  no_data_req_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && fifoFull) |-> !memReq);

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> !memReq);

  // R3
  fifo_write_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> memRspValid);

  // R7
  irq_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memRspValid));

  // R8
  irq_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(cfgWrEn && cfgAddr == CFG_AW'(2) && cfgWrData[0])) |=> irq);

  // R9
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispReq && fifoEmpty) |=> underrun);
endmodule

bind desc_frame_fetch fetch_chk #(.DATA_W(DATA_W), .CFG_AW(CFG_AW)) u_chk (.*);

// File: tb/sim_desc_frame_fetch.sv
module sim_desc_frame_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 1200;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgAddr;
  logic [31:0] cfgWrData;
  logic        memReq, memReady, memRspValid;
  logic [31:0] memAddr, memRspData;
  logic        fifoWrEn, fifoFull, fifoEmpty, dispReq, irq, underrun;
  logic [31:0] fifoWrData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  desc_frame_fetch u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .memReq(memReq), .memAddr(memAddr), .memReady(memReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .dispReq(dispReq), .irq(irq),
    .underrun(underrun)
  );

  typedef struct {
    logic [31:0] addr;
    bit          isData;
    bit          flag;   // interrupt due after this response
    string       tag;
  } ent_t;

  ent_t        q[$];
  logic [31:0] descMem[12];
  int          checks = 0, errors = 0;
  bit          started, outstanding, pendIsData, pendFlag, expIrq, expUnd;
  bit          lastIrqClr, lastUndClr;
  logic [31:0] pendAddr, headShadow, modelPtr;
  int          latCnt, accCnt, stallCnt;
  string       nextTag;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    if (a >= 32'h100 && a < 32'h130) return descMem[(a - 32'h100) >> 2];
    return {a[15:0], ~a[15:0]} ^ 32'h00FF_0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: expand one descriptor into expected requests
  task automatic appendDesc();
    logic [31:0] nxt, src, len, ctrl;
    ent_t e;
    nxt  = memWord(modelPtr);
    src  = memWord(modelPtr + 4);
    len  = memWord(modelPtr + 8) & ~32'h3;
    ctrl = memWord(modelPtr + 12);
    for (int k = 0; k < 4; k++) begin
      e.addr = modelPtr + 32'(4 * k);
      e.isData = 1'b0;
      e.flag = (k == 3) && (len == 0) && ctrl[0];
      e.tag = nextTag;
      q.push_back(e);
    end
    for (int k = 0; k < int'(len >> 2); k++) begin
      e.addr = src + 32'(4 * k);
      e.isData = 1'b1;
      e.flag = (k == int'(len >> 2) - 1) && ctrl[0];
      e.tag = "R3";
      q.push_back(e);
    end
    nextTag  = (len == 0) ? "R5" : "R4";
    modelPtr = nxt;
  endtask

  task automatic refill();
    while (q.size() < 8) appendDesc();
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit expReq, expWr, raise, clrI, clrU;
    // chain: 0x100 -> 0x110 -> 0x120 -> 0x100
    descMem = '{32'h110, 32'h0000_1000, 32'd16, 32'h1,
                32'h120, 32'h8000_0000, 32'd14, 32'h0,
                32'h100, 32'h0000_2000, 32'd0,  32'h1};
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = '0; cfgWrData = '0;
    memReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    fifoFull = 1'b0; fifoEmpty = 1'b0; dispReq = 1'b0;
    started = 0; outstanding = 0; expIrq = 0; expUnd = 0; accCnt = 0; stallCnt = 0;
    lastIrqClr = 0; lastUndClr = 0; headShadow = '0; nextTag = "R2";
    repeat (3) @(negedge clk);
    #1;
    chk(!memReq && !irq && !underrun && !fifoWrEn, "R1", "reset outputs",
        {28'd0, memReq, irq, underrun, fifoWrEn}, 32'd0);
    rstN = 1'b1;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      rstN = !(cyc >= 640 && cyc < 643);
      cfgWrEn = 1'b0;
      case (cyc)
        2:   cfgWrite(2'd0, 32'h100);
        3:   cfgWrite(2'd1, 32'h1);
        180: cfgWrite(2'd2, 32'h1);
        220: cfgWrite(2'd0, 32'h120);
        221: cfgWrite(2'd1, 32'h1);   // R10: start while running
        300: cfgWrite(2'd2, 32'h2);
        400: cfgWrite(2'd2, 32'h3);
        650: cfgWrite(2'd0, 32'h110);
        651: cfgWrite(2'd1, 32'h1);
        900: cfgWrite(2'd2, 32'h3);
        default: ;
      endcase
      memReady  = (cyc % 3) != 1;
      fifoFull  = (cyc % 23) < 5;
      dispReq   = (cyc % 61) == 9;
      fifoEmpty = (cyc % 3) == 0;
      memRspValid = 1'b0;
      if (!rstN) begin
        started = 0; outstanding = 0; q.delete(); expIrq = 0; expUnd = 0;
        lastIrqClr = 0; lastUndClr = 0; headShadow = '0;
      end else if (outstanding) begin
        if (latCnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = memWord(pendAddr);
        end else begin
          latCnt--;
        end
      end
      #1;
      expReq = started && !outstanding && !(q.size() > 0 && q[0].isData && fifoFull);
      chk(memReq == expReq, !rstN ? "R1" : ((q.size() > 0 && q[0].isData && fifoFull) ? "R6" : "R11"),
          "memReq", {31'd0, memReq}, {31'd0, expReq});
      if (memReq && expReq)
        chk(memAddr == q[0].addr, q[0].tag, "memAddr", memAddr, q[0].addr);
      expWr = memRspValid && outstanding && pendIsData;
      chk(fifoWrEn == expWr, "R3", "fifoWrEn", {31'd0, fifoWrEn}, {31'd0, expWr});
      if (fifoWrEn && expWr)
        chk(fifoWrData == memWord(pendAddr), "R3", "fifoWrData", fifoWrData, memWord(pendAddr));
      chk(irq == expIrq, !rstN ? "R1" : (lastIrqClr ? "R8" : "R7"), "irq",
          {31'd0, irq}, {31'd0, expIrq});
      chk(underrun == expUnd, !rstN ? "R1" : (lastUndClr ? "R8" : "R9"), "underrun",
          {31'd0, underrun}, {31'd0, expUnd});
      if (rstN) begin
        raise = memRspValid && outstanding && pendFlag;
        if (memRspValid && outstanding) outstanding = 0;
        clrI = cfgWrEn && cfgAddr == 2'd2 && cfgWrData[0];
        clrU = cfgWrEn && cfgAddr == 2'd2 && cfgWrData[1];
        expIrq = raise || (expIrq && !clrI);
        expUnd = (dispReq && fifoEmpty) || (expUnd && !clrU);
        lastIrqClr = clrI; lastUndClr = clrU;
        if (memReq && memReady && expReq) begin
          pendAddr = q[0].addr; pendIsData = q[0].isData; pendFlag = q[0].flag;
          void'(q.pop_front());
          outstanding = 1; latCnt = accCnt % 3; accCnt++;
          stallCnt = 0;
          refill();
        end else if (started) begin
          stallCnt++;
        end
        if (cfgWrEn && cfgAddr == 2'd0) headShadow = cfgWrData;
        if (cfgWrEn && cfgAddr == 2'd1 && cfgWrData[0] && !started) begin
          started = 1; modelPtr = headShadow; nextTag = "R2"; q.delete();
          refill();
        end
      end
      if (stallCnt > 100) begin
        errors++;
        $display("FAIL R11 watchdog: no request accepted for 100 cycles");
        break;
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule